// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

This block is a synchronous static memory of 18-bit words, each word split into two 9-bit byte lanes. A cycle opens when one of two address strobes is sampled low while all three chip selects are active. The processor strobe always opens a read. The controller strobe opens a read or a write, and the write controls are sampled on that same edge. After the opening edge, an internal burst sequencer steps through four neighbouring addresses. A mode input picks one of two orders: an XOR (interleaved) order or a wrapping linear order.

The datapath is a two-stage register pipeline. The address register holds the address, and the output register takes the word one edge later. Writes are decoded into one strobe per lane. A low global write enable writes both lanes. Otherwise each lane whose select is low is written, provided the byte-write enable is low. An output-drive flag tells the surrounding logic when the data output is valid and should be driven. The data output keeps its last value while the flag is low.

Top module: `burst_sram`

## Requirements
- R1: After reset, `dataDrive` is 0 and `dataOut` is all zeros.
- R2: When a read address is registered on an edge and `outEnN` is low with no lane select low, the word at that address appears on `dataOut` with `dataDrive` high one edge later.
- R3: An edge that samples `procStrobeN` low with all chip selects active starts a read and writes nothing, whatever `globalWrN`, `byteWrEnN`, `laneSelN` and `ctrlStrobeN` are.
- R4: A write with `globalWrN` low writes all 18 bits, whatever `laneSelN` and `byteWrEnN` are.
- R5: With `globalWrN` high and `byteWrEnN` low, each lane whose select is low is written. `laneSelN[0]` selects lane a (bits 8:0) and `laneSelN[1]` selects lane b (bits 17:9). Unselected bits keep their old value.
- R6: With `globalWrN` and `byteWrEnN` both high, nothing is written, even when lane selects are low.
- R7: Lane selects are ignored on the edge that samples `procStrobeN` low. On later edges of the burst they are sampled, and a write goes to the current burst address.
- R8: On any edge that does not sample `procStrobeN` low, a lane select sampled low drives `dataDrive` low on that edge, whatever `outEnN` is.
- R9: A cycle opened by `ctrlStrobeN` low (with `procStrobeN` high) samples the write controls on that same edge and writes `dataIn` at `addrIn`.
- R10: A strobe sampled low while any chip select is inactive (`chipSel0N` high, `chipSel1` low, or `chipSel2N` high) starts no cycle and writes nothing. It also ends the current burst, so `dataDrive` is low from the following edge on.
- R11: With `linearMode` low, the burst addresses are the start address with the two low bits XORed by the beat count 0, 1, 2, 3.
- R12: With `linearMode` high, the two low address bits count up from the start value, modulo 4, while the upper bits stay fixed.
- R13: `dataDrive` is the registered result of `outEnN` low and no write on that edge. While `dataDrive` is low, `dataOut` holds its value.
- R14: The burst address advances only on an edge with `advanceN` low, both strobes high and a burst open. Otherwise it stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addrIn | input | ADDR_W (8) | External word address |
| procStrobeN | input | 1 | Processor address strobe, active low, read-only start |
| ctrlStrobeN | input | 1 | Controller address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| chipSel0N | input | 1 | Chip select 0, active low |
| chipSel1 | input | 1 | Chip select 1, active high |
| chipSel2N | input | 1 | Chip select 2, active low |
| globalWrN | input | 1 | Whole-word write enable, active low |
| byteWrEnN | input | 1 | Byte-write enable, active low |
| laneSelN | input | 2 | Per-lane byte selects, active low, bit 0 = lane a |
| outEnN | input | 1 | Output enable, active low |
| linearMode | input | 1 | 1 = linear burst order, 0 = interleaved |
| dataIn | input | 18 | Write data |
| dataOut | output | 18 | Registered read data |
| dataDrive | output | 1 | Data-out valid / drive flag |

## Verification
The write decode is tried with a table of controller-strobe writes: global write, lane a only, lane b only, both lanes, byte enable off with selects low, and global write together with byte enable. Each write goes into a zeroed word, so the readback shows exactly which lanes were written. Processor-strobe cycles are run with every write control asserted, and with lane selects held low on the opening edge. These runs tell the read-only opening edge apart from a later write beat. Bursts from an odd start address tell the interleaved order (1,0,3,2) apart from the linear order (1,2,3,0), and a burst with advance held high tells stepping apart from holding. Output drive is tried with selects low but no write, with output enable high, and after a deselect. Each of these separates the drive flag from the data register, which must hold.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int NUM_LANES = 2;

  typedef struct packed {
    logic                 load;      // register a new start address
    logic                 useExt;    // write address comes from addrIn
    logic                 advance;   // step the burst counter
    logic [NUM_LANES-1:0] laneWr;    // per-lane write strobes
    logic                 driveNext; // output register loads and drives
  } ctrlCmd_t;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 procStrobeN,
  input  logic                 ctrlStrobeN,
  input  logic                 advanceN,
  input  logic                 chipSel0N,
  input  logic                 chipSel1,
  input  logic                 chipSel2N,
  input  logic                 globalWrN,
  input  logic                 byteWrEnN,
  input  logic [NUM_LANES-1:0] laneSelN,
  input  logic                 outEnN,
  output ctrlCmd_t             cmd
);
  logic active;
  logic chipsOn, procStart, ctrlStart, anyStrobe, continueEdge, selLow, deselect;
  logic [NUM_LANES-1:0] laneReq;

  always_comb begin
    chipsOn      = ~chipSel0N & chipSel1 & ~chipSel2N;
    anyStrobe    = ~procStrobeN | ~ctrlStrobeN;
    procStart    = ~procStrobeN & chipsOn;
    ctrlStart    = ~ctrlStrobeN & procStrobeN & chipsOn;
    deselect     = anyStrobe & ~chipsOn;
    continueEdge = active & ~anyStrobe;
    // global write overrides the per-lane selects
    if (!globalWrN)      laneReq = '1;
    else if (!byteWrEnN) laneReq = ~laneSelN;
    else                 laneReq = '0;
    // selects are not sampled on a processor-strobe edge
    selLow = procStrobeN & (|(~laneSelN));

    cmd.load      = procStart | ctrlStart;
    cmd.useExt    = ctrlStart;
    cmd.advance   = continueEdge & ~advanceN;
    cmd.laneWr    = (ctrlStart | continueEdge) ? laneReq : '0;
    cmd.driveNext = active & ~outEnN & ~(|cmd.laneWr) & ~selLow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      active <= 1'b0;
    else if (procStart | ctrlStart) active <= 1'b1;
    else if (deselect)              active <= 1'b0;
  end

  // R3
  // proc_read_only_chk
  proc_read_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN) |-> (cmd.laneWr == '0));

  // R4
  // global_lanes_chk
  global_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!globalWrN && cmd.laneWr != '0) |-> (&cmd.laneWr));

  // R6
  // bwe_off_chk
  bwe_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (globalWrN && byteWrEnN) |-> (cmd.laneWr == '0));

  // R10
  // chip_gate_chk
  chip_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSel1 && (!procStrobeN || !ctrlStrobeN)) |-> (cmd.laneWr == '0 && !cmd.load));
endmodule

// File: rtl/burst_sram_addr_seq.sv
module burst_sram_addr_seq
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlCmd_t          cmd,
  input  logic              linearMode,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] wrAddr
);
  localparam int BURST_W = $clog2(BURST_LEN);

  logic [ADDR_W-1:0]  baseAddr;
  logic [BURST_W-1:0] beatCnt;
  logic [BURST_W-1:0] lowBits;

  always_comb begin
    if (linearMode) lowBits = baseAddr[BURST_W-1:0] + beatCnt;
    else            lowBits = baseAddr[BURST_W-1:0] ^ beatCnt;
    curAddr = {baseAddr[ADDR_W-1:BURST_W], lowBits};
    wrAddr  = cmd.useExt ? extAddr : curAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      beatCnt  <= '0;
    end else if (cmd.load) begin
      baseAddr <= extAddr;
      beatCnt  <= '0;
    end else if (cmd.advance) begin
      beatCnt  <= beatCnt + BURST_W'(1);
    end
  end

  // R9
  // load_addr_chk
  load_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> (curAddr == $past(extAddr)));

  // R14
  // hold_addr_chk
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && !cmd.advance) |=> $stable(curAddr));
endmodule

// File: rtl/burst_sram_datapath.sv
module burst_sram_datapath
  import burst_sram_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LANE_W = 9,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int WORD_W = LANE_W * NUM_LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlCmd_t          cmd,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataDrive
);
  logic [WORD_W-1:0] readWord;

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (cmd.laneWr[g]) laneMem[wrAddr] <= dataIn[g*LANE_W +: LANE_W];
    end
    assign readWord[g*LANE_W +: LANE_W] = laneMem[curAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut   <= '0;
      dataDrive <= 1'b0;
    end else begin
      dataDrive <= cmd.driveNext;
      if (cmd.driveNext) dataOut <= readWord;
    end
  end

  // R13
  // hold_out_chk
  hold_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dataDrive) |-> $stable(dataOut));
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int LANE_W    = 9,
  parameter int BURST_LEN = 4,
  parameter int ADDR_W    = $clog2(DEPTH),
  parameter int WORD_W    = LANE_W * NUM_LANES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic                 procStrobeN,
  input  logic                 ctrlStrobeN,
  input  logic                 advanceN,
  input  logic                 chipSel0N,
  input  logic                 chipSel1,
  input  logic                 chipSel2N,
  input  logic                 globalWrN,
  input  logic                 byteWrEnN,
  input  logic [NUM_LANES-1:0] laneSelN,
  input  logic                 outEnN,
  input  logic                 linearMode,
  input  logic [WORD_W-1:0]    dataIn,
  output logic [WORD_W-1:0]    dataOut,
  output logic                 dataDrive
);
  ctrlCmd_t          cmd;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] wrAddr;

  burst_sram_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .chipSel0N(chipSel0N), .chipSel1(chipSel1),
    .chipSel2N(chipSel2N), .globalWrN(globalWrN), .byteWrEnN(byteWrEnN),
    .laneSelN(laneSelN), .outEnN(outEnN), .cmd(cmd)
  );

  burst_sram_addr_seq #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) uSeq (
    .clk(clk), .rstN(rstN), .cmd(cmd), .linearMode(linearMode),
    .extAddr(addrIn), .curAddr(curAddr), .wrAddr(wrAddr)
  );

  burst_sram_datapath #(.DEPTH(DEPTH), .LANE_W(LANE_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .curAddr(curAddr), .wrAddr(wrAddr),
    .dataIn(dataIn), .dataOut(dataOut), .dataDrive(dataDrive)
  );

  // R8
  // sel_drive_chk
  sel_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobeN && laneSelN != '1) |=> !dataDrive);
endmodule

// File: tb/sim_burst_sram.sv
`timescale 1ns/1ps
module sim_burst_sram;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addrIn = '0;
  logic        procStrobeN = 1'b1, ctrlStrobeN = 1'b1, advanceN = 1'b1;
  logic        chipSel0N = 1'b0, chipSel1 = 1'b1, chipSel2N = 1'b0;
  logic        globalWrN = 1'b1, byteWrEnN = 1'b1;
  logic [1:0]  laneSelN = 2'b11;
  logic        outEnN = 1'b0, linearMode = 1'b0;
  logic [17:0] dataIn = '0;
  logic [17:0] dataOut;
  logic        dataDrive;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  burst_sram u0 (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN), .chipSel0N(chipSel0N),
    .chipSel1(chipSel1), .chipSel2N(chipSel2N), .globalWrN(globalWrN),
    .byteWrEnN(byteWrEnN), .laneSelN(laneSelN), .outEnN(outEnN),
    .linearMode(linearMode), .dataIn(dataIn), .dataOut(dataOut), .dataDrive(dataDrive)
  );

  typedef struct packed {
    logic [7:0]  addr;
    logic [17:0] data;
    logic        gN;
    logic        bN;
    logic [1:0]  sel;
    logic [17:0] expect_;
  } vec_t;

  // controller-strobe writes into zeroed words, then readback
  localparam vec_t VECS [7] = '{
    '{8'h10, 18'h2A5A5, 1'b0, 1'b1, 2'b11, 18'h2A5A5},  // global write
    '{8'h11, 18'h1234F, 1'b1, 1'b0, 2'b10, 18'h0014F},  // lane a only
    '{8'h12, 18'h3FFFF, 1'b1, 1'b0, 2'b01, 18'h3FE00},  // lane b only
    '{8'h13, 18'h15555, 1'b1, 1'b0, 2'b00, 18'h15555},  // both lanes
    '{8'h14, 18'h3C3C3, 1'b1, 1'b1, 2'b00, 18'h00000},  // byte enable off
    '{8'h15, 18'h0ABCD, 1'b0, 1'b0, 2'b11, 18'h0ABCD},  // global beats selects
    '{8'h16, 18'h2FFFF, 1'b1, 1'b1, 2'b11, 18'h00000}   // no write
  };

  task automatic check(input string tag, input logic [17:0] got, input logic [17:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1; advanceN = 1'b1;
    globalWrN = 1'b1; byteWrEnN = 1'b1; laneSelN = 2'b11;
  endtask

  task automatic ctrlWrite(input logic [7:0] a, input logic [17:0] d,
                           input logic g, input logic b, input logic [1:0] s);
    ctrlStrobeN = 1'b0; addrIn = a; dataIn = d; globalWrN = g; byteWrEnN = b; laneSelN = s;
    step();
    idle();
  endtask

  task automatic readCheck(input string tag, input logic [7:0] a, input logic [17:0] exp);
    procStrobeN = 1'b0; addrIn = a;
    step();
    idle();
    step();
    check(tag, dataOut, exp);
    check({tag, " drive"}, {17'h0, dataDrive}, 18'h1);
  endtask

  initial begin
    #4_000_000;
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [17:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 dataOut", dataOut, 18'h0);
    check("R1 drive", {17'h0, dataDrive}, 18'h0);
    rstN = 1'b1;
    @(negedge clk);

    // table: R9 start-edge write, R4 R5 R6 lane decode, R2 readback
    foreach (VECS[i]) begin
      ctrlWrite(VECS[i].addr, 18'h0, 1'b0, 1'b1, 2'b11);
      ctrlWrite(VECS[i].addr, VECS[i].data, VECS[i].gN, VECS[i].bN, VECS[i].sel);
      readCheck("R9/R4/R5/R6/R2 table", VECS[i].addr, VECS[i].expect_);
    end

    // R3 processor strobe is read-only even with every write control low
    ctrlWrite(8'h20, 18'h00111, 1'b0, 1'b1, 2'b11);
    procStrobeN = 1'b0; ctrlStrobeN = 1'b0; addrIn = 8'h20; dataIn = 18'h3FFFF;
    globalWrN = 1'b0; byteWrEnN = 1'b0; laneSelN = 2'b00;
    step();
    idle();
    step();
    check("R3 first read", dataOut, 18'h00111);
    readCheck("R3 reread", 8'h20, 18'h00111);

    // R7 selects ignored on processor-strobe edge
    ctrlWrite(8'h30, 18'h00AAA, 1'b0, 1'b1, 2'b11);
    procStrobeN = 1'b0; addrIn = 8'h30; byteWrEnN = 1'b0; laneSelN = 2'b00; dataIn = 18'h3FFFF;
    step();
    idle();
    step();
    check("R7 ignored on start edge", dataOut, 18'h00AAA);

    // R7 later edge write, R8 drive off, R13 data held
    ctrlWrite(8'h31, 18'h0, 1'b0, 1'b1, 2'b11);
    procStrobeN = 1'b0; addrIn = 8'h31;
    step();
    held = dataOut;
    procStrobeN = 1'b1; byteWrEnN = 1'b0; laneSelN = 2'b00; dataIn = 18'h1F0F0;
    step();
    check("R8 drive off on write beat", {17'h0, dataDrive}, 18'h0);
    check("R13 hold while not driven", dataOut, held);
    idle();
    readCheck("R7 later-edge write", 8'h31, 18'h1F0F0);

    // R8 select low without a write still blocks drive
    procStrobeN = 1'b0; addrIn = 8'h31;
    step();
    idle();
    laneSelN = 2'b10;
    step();
    check("R8 select without write", {17'h0, dataDrive}, 18'h0);
    idle();
    step();
    check("R8 drive back", {17'h0, dataDrive}, 18'h1);
    check("R8 data after block", dataOut, 18'h1F0F0);

    // R13 output enable high
    procStrobeN = 1'b0; addrIn = 8'h30;
    step();
    held = dataOut;
    idle();
    outEnN = 1'b1;
    step();
    check("R13 oe high drive", {17'h0, dataDrive}, 18'h0);
    check("R13 oe high hold", dataOut, held);
    outEnN = 1'b0;

    // R10 chip selects gate cycle start and deselect
    ctrlWrite(8'h40, 18'h00123, 1'b0, 1'b1, 2'b11);
    chipSel1 = 1'b0;
    ctrlWrite(8'h40, 18'h3FFFF, 1'b0, 1'b1, 2'b11);
    chipSel1 = 1'b1;
    step();
    check("R10 deselected drive", {17'h0, dataDrive}, 18'h0);
    chipSel0N = 1'b1;
    procStrobeN = 1'b0; addrIn = 8'h41;
    step();
    idle();
    chipSel0N = 1'b0;
    step();
    check("R10 no start with cs0 off", {17'h0, dataDrive}, 18'h0);
    readCheck("R10 no write when deselected", 8'h40, 18'h00123);

    // R11 interleaved and R12 linear burst orders from start 0x51
    for (int j = 0; j < 4; j++) ctrlWrite(8'h50 + 8'(j), 18'h00100 + 18'(j), 1'b0, 1'b1, 2'b11);
    for (int m = 0; m < 2; m++) begin
      linearMode = (m == 1);
      procStrobeN = 1'b0; addrIn = 8'h51;
      step();
      idle();
      advanceN = 1'b0;
      for (int k = 0; k < 4; k++) begin
        logic [1:0] lowA;
        step();
        lowA = (m == 1) ? 2'(1 + k) : (2'b01 ^ 2'(k));
        check((m == 1) ? "R12 linear beat" : "R11 interleaved beat", dataOut, 18'h00100 + 18'(lowA));
      end
      advanceN = 1'b1;
    end
    linearMode = 1'b0;

    // R14 no advance with advanceN high
    procStrobeN = 1'b0; addrIn = 8'h51;
    step();
    idle();
    step();
    check("R14 hold beat 1", dataOut, 18'h00101);
    step();
    check("R14 hold beat 2", dataOut, 18'h00101);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule